// File: doc/BRIEF.md
# Paged Byte Memory Window

This block lets a host with an eight-bit register address space reach a 1024-byte read-only memory through a 128-byte window. The memory is divided into eight pages of 128 bytes. The host picks a page by writing a mode register at address 0x0B. Any read in the upper half of the address space (0x80 to 0xFF) then returns a byte from the selected page. Bits [2:0] of the mode register hold the page number. Bit 3 holds an addressing-mode flag, where 0 means one-byte addressing. The flag is stored and can be read back, but it does not change how the window behaves.

The host issues single-cycle reads and writes on a simple strobe bus. Each read returns one byte exactly one clock later, qualified by a valid strobe. A sequential-read strobe continues from the byte after the previous window read. The offset wraps inside the current page and never moves into the next page. The memory contents are loaded through a separate initialization write port, which uses flat byte addresses.

Top module: `pgwin_top`

## Requirements
- R1: After reset the valid strobe is low, and the mode register reads 0x00.
- R2: A host write to 0x0B stores data bits [3:0]. A read of 0x0B returns those four bits, with bits [7:4] always reading zero.
- R3: A read at an address A in 0x80..0xFF returns memory byte (page*128 + A[6:0]) on the clock after the read strobe, with valid high for exactly that one cycle for each read.
- R4: Host writes have no effect on the memory or on the mode register unless they target 0x0B. This includes writes into the window 0x80..0xFF.
- R5: A page change applies to the first read issued in the cycle after the mode write. A read issued before the change returns old-page data, and no read issued after the change returns old-page data.
- R6: A sequential read, requested by asserting the sequential strobe together with the read strobe, returns the byte at (previous window offset + 1) mod 128 in the current page. Offset 127 is followed by offset 0 of the same page. After reset the sequential offset is 0.
- R7: A read of any address below 0x80 other than 0x0B returns 0x00.
- R8: A write on the initialization port stores its data at flat byte address initAddr (page in bits [9:7], offset in bits [6:0]). A later window read of that page and offset returns the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostAddr | input | 8 | Host register address |
| hostWrEn | input | 1 | Host write strobe |
| hostWrData | input | 8 | Host write data |
| hostRdEn | input | 1 | Host read strobe |
| hostRdSeq | input | 1 | With hostRdEn: read the next window offset and ignore hostAddr |
| hostRdData | output | 8 | Read data, valid when hostRdValid is high |
| hostRdValid | output | 1 | High for one cycle, one clock after each read strobe |
| initAddr | input | 10 | Initialization flat byte address |
| initData | input | 8 | Initialization data |
| initWrEn | input | 1 | Initialization write strobe |

## Verification
A corrupted page register would show up on the very next window read as a byte from the wrong page. For that reason the reads are spread across every page, and each page change is followed at once by a read. A stale sequential-offset register would return a neighbouring byte on the first sequential read after it, and a broken wrap would step past offset 127 into the following page. Both are checked at the 127-to-0 boundary. Any lost or extra read strobe would shift the valid stream by one cycle. The scoreboard exposes such a shift because it pairs every returned byte with the read that requested it.

// File: rtl/pgwin_pkg.sv
package pgwin_pkg;

  // source of the byte returned for a host read
  typedef enum logic [1:0] {
    SRC_ZERO = 2'd0,
    SRC_MEM  = 2'd1,
    SRC_MODE = 2'd2
  } rdSrc_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   rdFire;
    rdSrc_e src;
  } rdCmd_t;

endpackage

// File: rtl/pgwin_ctrl.sv
module pgwin_ctrl
  import pgwin_pkg::*;
#(
  parameter int HOST_AW    = 8,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 128,
  parameter int NUM_PAGES  = 8,
  parameter logic [HOST_AW-1:0] MODE_ADDR = 'h0B,
  parameter logic [HOST_AW-1:0] WIN_BASE  = 'h80,
  localparam int OFF_W  = $clog2(PAGE_BYTES),
  localparam int PAGE_W = $clog2(NUM_PAGES),
  localparam int MEM_AW = OFF_W + PAGE_W,
  localparam int MODE_W = PAGE_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic               hostWrEn,
  input  logic [DATA_W-1:0]  hostWrData,
  input  logic               hostRdEn,
  input  logic               hostRdSeq,
  output rdCmd_t             cmd,
  output logic [MEM_AW-1:0]  memAddr,
  output logic [DATA_W-1:0]  regValue
);

  logic [MODE_W-1:0] modeReg;
  logic [MODE_W-1:0] modeNext;
  logic [OFF_W-1:0]  nextOff;
  logic [OFF_W-1:0]  offSel;
  logic              modeWrite;
  logic              inWindow;
  logic              winRead;

  assign modeWrite = hostWrEn && (hostAddr == MODE_ADDR);
  assign modeNext  = modeWrite ? hostWrData[MODE_W-1:0] : modeReg;
  assign inWindow  = (hostAddr >= WIN_BASE);
  assign winRead   = hostRdEn && (hostRdSeq || inWindow);
  assign offSel    = hostRdSeq ? nextOff : hostAddr[OFF_W-1:0];

  // the page comes from the register value as of this cycle
  assign memAddr  = {modeNext[PAGE_W-1:0], offSel};
  assign regValue = {{(DATA_W-MODE_W){1'b0}}, modeNext};

  always_comb begin
    cmd.rdFire = hostRdEn;
    if (winRead)                       cmd.src = SRC_MEM;
    else if (hostAddr == MODE_ADDR)    cmd.src = SRC_MODE;
    else                               cmd.src = SRC_ZERO;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= '0;
      nextOff <= '0;
    end else begin
      modeReg <= modeNext;
      if (winRead) nextOff <= OFF_W'(offSel + 1'b1);
    end
  end

  // R2: the low mode bits of a write land in the register, upper bits dropped
  p_mode_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    modeWrite && (|hostWrData[DATA_W-1:MODE_W]) |=> modeReg == $past(hostWrData[MODE_W-1:0]));

  // R4: writes elsewhere leave the mode register alone
  p_mode_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    hostWrEn && (hostAddr != MODE_ADDR) |=> modeReg == $past(modeReg));

  // R6: offset 127 wraps to 0 of the same page
  p_seq_wrap_r6: assert property (@(posedge clk) disable iff (!rstN)
    winRead && hostRdSeq && (nextOff == '1) |=> nextOff == '0);

endmodule

// File: rtl/pgwin_datapath.sv
module pgwin_datapath
  import pgwin_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int MEM_AW = 10,
  localparam int MEM_DEPTH = 1 << MEM_AW
) (
  input  logic              clk,
  input  logic              rstN,
  input  rdCmd_t            cmd,
  input  logic [MEM_AW-1:0] memAddr,
  input  logic [DATA_W-1:0] regValue,
  input  logic [MEM_AW-1:0] initAddr,
  input  logic [DATA_W-1:0] initData,
  input  logic              initWrEn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  logic [DATA_W-1:0] mem [MEM_DEPTH];
  logic [DATA_W-1:0] memQ;
  logic [DATA_W-1:0] regQ;
  rdSrc_e            srcQ;

  // synchronous byte memory, written only by the init port
  always_ff @(posedge clk) begin
    if (initWrEn) mem[initAddr] <= initData;
    if (cmd.rdFire && (cmd.src == SRC_MEM)) memQ <= mem[memAddr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      srcQ    <= SRC_ZERO;
      regQ    <= '0;
    end else begin
      rdValid <= cmd.rdFire;
      if (cmd.rdFire) begin
        srcQ <= cmd.src;
        regQ <= regValue;
      end
    end
  end

  always_comb begin
    case (srcQ)
      SRC_MEM:  rdData = memQ;
      SRC_MODE: rdData = regQ;
      default:  rdData = '0;
    endcase
  end

  // R3: exactly one valid cycle follows each read strobe
  p_valid_follows_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmd.rdFire |=> rdValid);
  p_valid_only_r3: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.rdFire |=> !rdValid);

endmodule

// File: rtl/pgwin_top.sv
module pgwin_top
  import pgwin_pkg::*;
#(
  parameter int HOST_AW    = 8,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 128,
  parameter int NUM_PAGES  = 8,
  localparam int OFF_W  = $clog2(PAGE_BYTES),
  localparam int PAGE_W = $clog2(NUM_PAGES),
  localparam int MEM_AW = OFF_W + PAGE_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic               hostWrEn,
  input  logic [DATA_W-1:0]  hostWrData,
  input  logic               hostRdEn,
  input  logic               hostRdSeq,
  output logic [DATA_W-1:0]  hostRdData,
  output logic               hostRdValid,
  input  logic [MEM_AW-1:0]  initAddr,
  input  logic [DATA_W-1:0]  initData,
  input  logic               initWrEn
);

  localparam logic [HOST_AW-1:0] MODE_ADDR = 'h0B;
  localparam logic [HOST_AW-1:0] WIN_BASE  = HOST_AW'(PAGE_BYTES);

  rdCmd_t            cmd;
  logic [MEM_AW-1:0] memAddr;
  logic [DATA_W-1:0] regValue;

  pgwin_ctrl #(
    .HOST_AW(HOST_AW), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES),
    .NUM_PAGES(NUM_PAGES), .MODE_ADDR(MODE_ADDR), .WIN_BASE(WIN_BASE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
    .hostWrData(hostWrData), .hostRdEn(hostRdEn), .hostRdSeq(hostRdSeq),
    .cmd(cmd), .memAddr(memAddr), .regValue(regValue)
  );

  pgwin_datapath #(.DATA_W(DATA_W), .MEM_AW(MEM_AW)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .memAddr(memAddr), .regValue(regValue),
    .initAddr(initAddr), .initData(initData), .initWrEn(initWrEn),
    .rdData(hostRdData), .rdValid(hostRdValid)
  );

  // R7: plain reads outside the window and mode register come back zero
  p_hole_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    hostRdValid && $past(hostRdEn && !hostRdSeq && (hostAddr < WIN_BASE) && (hostAddr != MODE_ADDR))
    |-> hostRdData == '0);

  // R2: upper mode bits read zero
  p_mode_upper_r2: assert property (@(posedge clk) disable iff (!rstN)
    hostRdValid && $past(hostRdEn && !hostRdSeq && (hostAddr == MODE_ADDR))
    |-> hostRdData[DATA_W-1:PAGE_W+1] == '0);

endmodule

// File: tb/pgwin_top_bench.sv
module pgwin_top_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] hostAddr = '0;
  logic       hostWrEn = 1'b0;
  logic [7:0] hostWrData = '0;
  logic       hostRdEn = 1'b0;
  logic       hostRdSeq = 1'b0;
  logic [7:0] hostRdData;
  logic       hostRdValid;
  logic [9:0] initAddr = '0;
  logic [7:0] initData = '0;
  logic       initWrEn = 1'b0;

  always #4 clk = ~clk;

  pgwin_top u_pgwin_top (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
    .hostWrData(hostWrData), .hostRdEn(hostRdEn), .hostRdSeq(hostRdSeq),
    .hostRdData(hostRdData), .hostRdValid(hostRdValid),
    .initAddr(initAddr), .initData(initData), .initWrEn(initWrEn)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] model [1024];
  logic [3:0] modeM = '0;
  logic [6:0] nextOffM = '0;
  logic [7:0] expQ [$];
  string      tagQ [$];

  function automatic logic [7:0] pattern(int i);
    return 8'(((i * 37) + ((i >> 7) * 11)) ^ 8'hA5);
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    hostWrEn = 0; hostRdEn = 0; hostRdSeq = 0; initWrEn = 0;
  endtask

  task automatic busWrite(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    hostAddr = a; hostWrData = d; hostWrEn = 1; hostRdEn = 0; hostRdSeq = 0; initWrEn = 0;
    if (a == 8'h0B) modeM = d[3:0];
  endtask

  task automatic busRead(logic [7:0] a, string tag);
    logic [7:0] e;
    @(negedge clk);
    hostAddr = a; hostWrEn = 0; hostRdEn = 1; hostRdSeq = 0; initWrEn = 0;
    if (a >= 8'h80) begin
      e = model[{modeM[2:0], a[6:0]}];
      nextOffM = a[6:0] + 7'd1;
    end else if (a == 8'h0B) e = {4'h0, modeM};
    else e = 8'h00;
    expQ.push_back(e); tagQ.push_back(tag);
  endtask

  task automatic seqRead(string tag);
    @(negedge clk);
    hostAddr = 8'h00; hostWrEn = 0; hostRdEn = 1; hostRdSeq = 1; initWrEn = 0;
    expQ.push_back(model[{modeM[2:0], nextOffM}]); tagQ.push_back(tag);
    nextOffM = nextOffM + 7'd1;
  endtask

  task automatic initWrite(int a, logic [7:0] d);
    @(negedge clk);
    hostWrEn = 0; hostRdEn = 0; hostRdSeq = 0;
    initAddr = 10'(a); initData = d; initWrEn = 1;
    model[a] = d;
  endtask

  // monitor: pair every valid byte with the oldest outstanding read
  always @(negedge clk) begin
    if (rstN && hostRdValid) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R3 unexpected valid actual=%h expected=none", hostRdData);
      end else begin
        check(tagQ.pop_front(), hostRdData, expQ.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R1 valid low after reset", {7'd0, hostRdValid}, 8'h00);
    busRead(8'h0B, "R1 mode reset value");
    idle();

    for (int i = 0; i < 1024; i++) initWrite(i, pattern(i));
    idle();

    // R6: sequential offset starts at 0 after reset
    seqRead("R6 seq after reset");
    seqRead("R6 seq second");

    // R2: mode read-back
    busWrite(8'h0B, 8'h03);
    busRead(8'h0B, "R2 mode readback");
    busWrite(8'h0B, 8'hFA);
    busRead(8'h0B, "R2 upper bits zero");

    // R3: several offsets of page 2, back to back
    busRead(8'h80, "R3 page2 first");
    busRead(8'hFF, "R3 page2 last");
    busRead(8'hA3, "R3 page2 mid");
    idle();

    // R5: old page before change, new page right after
    busRead(8'h90, "R5 before change");
    busWrite(8'h0B, 8'h05);
    busRead(8'h90, "R5 after change");
    busWrite(8'h0B, 8'h01);
    busRead(8'h91, "R5 second change");

    // R4: writes ignored
    busWrite(8'h85, 8'hEE);
    busRead(8'h85, "R4 window write ignored");
    busWrite(8'h20, 8'h07);
    busRead(8'h0B, "R4 mode kept");
    busWrite(8'hC0, 8'h06);
    busRead(8'h0B, "R4 mode kept after window write");

    // R6: wrap from 127 to 0 in same page
    busWrite(8'h0B, 8'h04);
    busRead(8'hFE, "R6 start");
    seqRead("R6 offset 127");
    seqRead("R6 wrap to 0");
    seqRead("R6 offset 1");

    // R7: unmapped low addresses
    busRead(8'h00, "R7 addr 00");
    busRead(8'h20, "R7 addr 20");
    busRead(8'h7F, "R7 addr 7F");

    // R8: runtime init write then read
    initWrite(6 * 128 + 5, 8'h3C);
    busWrite(8'h0B, 8'h06);
    busRead(8'h85, "R8 init byte");

    // R3: every page at a fixed offset
    for (int p = 0; p < 8; p++) begin
      busWrite(8'h0B, 8'(p));
      busRead(8'hC4, "R3 page sweep");
    end
    idle();
    repeat (4) @(negedge clk);

    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R3 missing valid actual=%0d expected=0", expQ.size());
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule